// File: doc/BRIEF.md
# Boundary Vector Frame Packer

This block sits in a raster pixel stream in front of a two-dimensional transform engine. It accepts a grayscale frame of `ROWS` x `COLS` unsigned pixels, one per handshake, in row-major order. Every pixel is forwarded unchanged. While the frame passes, the block keeps the pixels of the top row and the left column in small on-chip stores. When the bottom row and the right column arrive, it replaces each stored pixel with the difference between the two opposite edges.

After the last pixel it emits two vectors. The first holds the top row of the border image, where each element is the sum of the row-wise and column-wise edge discontinuities. The second holds the left column of that border image. A downstream transform stage can rebuild the whole border image from these two vectors and its negated mirror, so the full border image never travels on the stream.

Output samples are `PIX_W+2` bits wide in two's complement, because a corner element adds two edge differences. Backpressure on the output stalls the input. The input is refused while the two vectors are being emitted.

Top module: `bvp_frame_packer`

## Requirements
- R1: Each accepted pixel leaves the block unchanged, in arrival order, zero-extended to `PIX_W+2` bits.
- R2: Every frame leaves the block as exactly `ROWS*COLS + ROWS + COLS` samples. The pixels come first, then `COLS` row-vector elements, then `ROWS` column-vector elements.
- R3: Row-vector element j, for 0 < j < COLS-1, equals I(ROWS-1,j) - I(0,j).
- R4: Column-vector element i, for 0 < i < ROWS-1, equals I(i,COLS-1) - I(i,0).
- R5: Row-vector element 0 equals I(ROWS-1,0) - I(0,0) + (I(0,COLS-1) - I(0,0)). Element COLS-1 equals I(ROWS-1,COLS-1) - I(0,COLS-1) - (I(0,COLS-1) - I(0,0)).
- R6: Column-vector element 0 equals I(0,COLS-1) - I(0,0) + (I(ROWS-1,0) - I(0,0)). Element ROWS-1 equals I(ROWS-1,COLS-1) - I(ROWS-1,0) - (I(ROWS-1,0) - I(0,0)).
- R7: Vector elements are signed two's complement of `PIX_W+2` bits and are exact for all pixel values, including the extremes of -(2*(2^PIX_W-1)) and +(2*(2^PIX_W-1)).
- R8: `out_sof` is high only on the first pixel of a frame. `out_eof` is high only on the last column-vector element.
- R9: While `out_valid` is high and `out_ready` is low, the output sample and its flags hold. `in_ready` is low while the vectors are being emitted. No sample is lost or repeated.
- R10: An accepted pixel with `in_sof` high is treated as pixel (0,0) of a new frame, whatever position was reached before.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_data | input | PIX_W | Unsigned pixel |
| in_sof | input | 1 | Pixel is the first of a frame |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the sample |
| out_data | output | PIX_W+2 | Pixel (zero-extended) or signed border element |
| out_sof | output | 1 | First pixel of a frame |
| out_eof | output | 1 | Last sample of a frame |

## Verification
A pixel accepted at a clock edge sits in the single output register right after that edge, so it is due one cycle later. The first row-vector element is loaded at the next output-register load after the last pixel is accepted. Each further vector element follows one load later, and a load happens on every cycle in which the register is empty or drained. The bench feeds a behavioural queue model when a handshake is seen at the input, and it pops that queue only when a handshake is seen at the output. Both are sampled just after the falling edge, so the comparisons follow the design's stall pattern and do not assume a fixed latency. A sample held under backpressure is checked for stability on the next cycle.

// File: rtl/bvp_pkg.sv
package bvp_pkg;
  typedef enum logic [1:0] {
    PH_PIX  = 2'd0,
    PH_ROWV = 2'd1,
    PH_COLV = 2'd2
  } bvp_phase_e;
endpackage

// File: rtl/bvp_edge_store.sv
// One edge of the frame: the first edge is written raw, the opposite edge
// overwrites each entry with (opposite - first).
module bvp_edge_store #(
  parameter int DEPTH = 6,
  parameter int PIX_W = 16
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic                       wr_opp,
  input  logic [$clog2(DEPTH)-1:0]   wr_idx,
  input  logic [PIX_W-1:0]           wr_pix,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic signed [PIX_W+1:0]    rd_val
);
  localparam int OUT_W = PIX_W + 2;

  logic signed [OUT_W-1:0] mem [DEPTH];
  logic signed [OUT_W-1:0] pix_ext;
  logic signed [OUT_W-1:0] wr_val;

  assign pix_ext = {{(OUT_W-PIX_W){1'b0}}, wr_pix};
  assign wr_val  = wr_opp ? (pix_ext - mem[wr_idx]) : pix_ext;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  assign rd_val = mem[rd_idx];

  // R2: the sequencer only addresses entries that exist
  always_comb begin
    if (wr_en) a_r2_wr_idx_in_range: assert (int'(wr_idx) < DEPTH);
  end
endmodule

// File: rtl/bvp_seq.sv
module bvp_seq
  import bvp_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_en,
  input  logic                        in_valid,
  input  logic                        in_sof,
  output logic                        in_ready,
  output logic                        acc,
  output bvp_phase_e                  phase,
  output logic [$clog2(ROWS)-1:0]     pos_r,
  output logic [$clog2(COLS)-1:0]     pos_c,
  output logic [$clog2((ROWS > COLS) ? ROWS : COLS)-1:0] vec_k
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int KW = $clog2((ROWS > COLS) ? ROWS : COLS);
  localparam logic [RW-1:0] R_LAST  = RW'(ROWS - 1);
  localparam logic [CW-1:0] C_LAST  = CW'(COLS - 1);
  localparam logic [KW-1:0] KR_LAST = KW'(ROWS - 1);
  localparam logic [KW-1:0] KC_LAST = KW'(COLS - 1);

  logic [RW-1:0] r_q;
  logic [CW-1:0] c_q;

  assign in_ready = (phase == PH_PIX) && load_en;
  assign acc      = in_valid && in_ready;
  assign pos_r    = in_sof ? '0 : r_q;
  assign pos_c    = in_sof ? '0 : c_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_PIX;
      r_q   <= '0;
      c_q   <= '0;
      vec_k <= '0;
    end else begin
      unique case (phase)
        PH_PIX: if (acc) begin
          if (pos_c == C_LAST) begin
            c_q <= '0;
            if (pos_r == R_LAST) begin
              r_q   <= '0;
              vec_k <= '0;
              phase <= PH_ROWV;
            end else begin
              r_q <= pos_r + 1'b1;
            end
          end else begin
            c_q <= pos_c + 1'b1;
            r_q <= pos_r;
          end
        end
        PH_ROWV: if (load_en) begin
          if (vec_k == KC_LAST) begin
            vec_k <= '0;
            phase <= PH_COLV;
          end else begin
            vec_k <= vec_k + 1'b1;
          end
        end
        PH_COLV: if (load_en) begin
          if (vec_k == KR_LAST) begin
            vec_k <= '0;
            phase <= PH_PIX;
          end else begin
            vec_k <= vec_k + 1'b1;
          end
        end
        default: phase <= PH_PIX;
      endcase
    end
  end

  // R9: no pixel is taken while the vectors are being emitted
  a_r9_no_input_in_append: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_PIX) |-> !in_ready);
endmodule

// File: rtl/bvp_frame_packer.sv
module bvp_frame_packer
  import bvp_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int COLS  = 5,
  parameter int PIX_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_data,
  input  logic                 in_sof,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PIX_W+1:0]     out_data,
  output logic                 out_sof,
  output logic                 out_eof
);
  localparam int OUT_W = PIX_W + 2;
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int KW    = $clog2((ROWS > COLS) ? ROWS : COLS);
  localparam int TOTAL = ROWS * COLS + ROWS + COLS;
  localparam int NW    = $clog2(TOTAL + 1);
  localparam logic [RW-1:0] R_LAST  = RW'(ROWS - 1);
  localparam logic [CW-1:0] C_LAST  = CW'(COLS - 1);
  localparam logic [KW-1:0] KR_LAST = KW'(ROWS - 1);
  localparam logic [KW-1:0] KC_LAST = KW'(COLS - 1);
  localparam logic [NW-1:0] N_LAST  = NW'(TOTAL - 1);

  logic                    load_en;
  logic                    acc;
  bvp_phase_e              phase;
  logic [RW-1:0]           pos_r;
  logic [CW-1:0]           pos_c;
  logic [KW-1:0]           vec_k;
  logic signed [OUT_W-1:0] row_rd, col_rd;
  logic signed [OUT_W-1:0] vec_val;
  logic [CW-1:0]           row_rd_idx;
  logic [RW-1:0]           col_rd_idx;

  assign load_en = !out_valid || out_ready;

  bvp_seq #(.ROWS(ROWS), .COLS(COLS)) seq_i (
    .clk(clk), .rst(rst), .load_en(load_en), .in_valid(in_valid),
    .in_sof(in_sof), .in_ready(in_ready), .acc(acc), .phase(phase),
    .pos_r(pos_r), .pos_c(pos_c), .vec_k(vec_k)
  );

  // The unselected store is read at entry 0, which holds the other
  // edge's corner difference needed for the corner elements.
  assign row_rd_idx = (phase == PH_ROWV) ? CW'(vec_k) : '0;
  assign col_rd_idx = (phase == PH_COLV) ? RW'(vec_k) : '0;

  bvp_edge_store #(.DEPTH(COLS), .PIX_W(PIX_W)) row_store_i (
    .clk(clk),
    .wr_en(acc && ((pos_r == '0) || (pos_r == R_LAST))),
    .wr_opp(pos_r == R_LAST),
    .wr_idx(pos_c), .wr_pix(in_data),
    .rd_idx(row_rd_idx), .rd_val(row_rd)
  );

  bvp_edge_store #(.DEPTH(ROWS), .PIX_W(PIX_W)) col_store_i (
    .clk(clk),
    .wr_en(acc && ((pos_c == '0) || (pos_c == C_LAST))),
    .wr_opp(pos_c == C_LAST),
    .wr_idx(pos_r), .wr_pix(in_data),
    .rd_idx(col_rd_idx), .rd_val(col_rd)
  );

  always_comb begin
    vec_val = '0;
    if (phase == PH_ROWV) begin
      vec_val = row_rd;
      if (vec_k == '0)     vec_val = row_rd + col_rd;
      if (vec_k == KC_LAST) vec_val = row_rd - col_rd;
    end else if (phase == PH_COLV) begin
      vec_val = col_rd;
      if (vec_k == '0)     vec_val = col_rd + row_rd;
      if (vec_k == KR_LAST) vec_val = col_rd - row_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (load_en) begin
      if (phase == PH_PIX) begin
        out_valid <= in_valid;
        out_data  <= {2'b00, in_data};
        out_sof   <= (pos_r == '0) && (pos_c == '0);
        out_eof   <= 1'b0;
      end else begin
        out_valid <= 1'b1;
        out_data  <= vec_val;
        out_sof   <= 1'b0;
        out_eof   <= (phase == PH_COLV) && (vec_k == KR_LAST);
      end
    end
  end

  // Samples handed on since the last frame start, for the length check
  logic [NW-1:0] sent_q;
  always_ff @(posedge clk) begin
    if (rst) sent_q <= '0;
    else if (out_valid && out_ready)
      sent_q <= out_eof ? '0 : (out_sof ? NW'(1) : sent_q + 1'b1);
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sof) && $stable(out_eof)));

  a_r2_frame_length: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eof) |-> (sent_q == N_LAST));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_sof && out_eof));

  a_r8_eof_returns_to_pixels: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eof) |=> (phase == PH_PIX));
endmodule

// File: tb/bvp_frame_packer_tb_top.sv
module bvp_frame_packer_tb_top;
  localparam int ROWS  = 6;
  localparam int COLS  = 5;
  localparam int PIX_W = 16;
  localparam int OUT_W = PIX_W + 2;
  localparam int LIMIT = 100000;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_ready, in_sof;
  logic [PIX_W-1:0] in_data;
  logic             out_valid, out_ready, out_sof, out_eof;
  logic [OUT_W-1:0] out_data;

  always #4 clk = ~clk;

  bvp_frame_packer #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof)
  );

  int checks = 0, failures = 0, cycles = 0;
  int unsigned lcg = 32'h1234_5678;
  bit ready_stall = 0, valid_gap = 0;
  string xtag = "";

  int    q_data[$];
  bit    q_sof[$];
  bit    q_eof[$];
  string q_tag[$];

  int img[ROWS][COLS];
  int mr = 0, mc = 0;
  bit have = 0;
  int pend_pix = 0;
  bit pend_sof = 0;
  bit prev_hold = 0;
  int prev_data = 0;

  function automatic bit rnd_bit();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic push_exp(int d, bit s, bit e, string t);
    q_data.push_back(d); q_sof.push_back(s); q_eof.push_back(e);
    q_tag.push_back({t, xtag});
  endtask

  // Behavioural reference: border vectors built from the stored frame
  task automatic build_vectors();
    int cr, cc, v;
    cr = img[0][COLS-1] - img[0][0];
    cc = img[ROWS-1][0] - img[0][0];
    for (int j = 0; j < COLS; j++) begin
      v = img[ROWS-1][j] - img[0][j];
      if (j == 0)      v = v + cr;
      if (j == COLS-1) v = v - cr;
      push_exp(v, 0, 0, (j == 0 || j == COLS-1) ? "R5" : "R3");
    end
    for (int i = 0; i < ROWS; i++) begin
      v = img[i][COLS-1] - img[i][0];
      if (i == 0)      v = v + cc;
      if (i == ROWS-1) v = v - cc;
      push_exp(v, 0, i == ROWS-1, (i == 0 || i == ROWS-1) ? "R6" : "R4");
    end
  endtask

  task automatic model_accept(int pix, bit sof);
    if (sof) begin mr = 0; mc = 0; end
    push_exp(pix, (mr == 0 && mc == 0), 0, "R1");
    img[mr][mc] = pix;
    if (mc == COLS-1) begin
      mc = 0;
      if (mr == ROWS-1) begin mr = 0; build_vectors(); end
      else mr = mr + 1;
    end else mc = mc + 1;
  endtask

  task automatic step();
    int act;
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      check(0, "R2", "watchdog expired", cycles, LIMIT);
      finish_run();
    end
    out_ready = ready_stall ? rnd_bit() : 1'b1;
    in_valid  = have && (valid_gap ? rnd_bit() : 1'b1);
    in_data   = PIX_W'(pend_pix);
    in_sof    = pend_sof;
    #1;
    act = $signed(out_data);
    if (prev_hold)
      check(out_valid && act == prev_data, "R9", "held sample", act, prev_data);
    prev_hold = out_valid && !out_ready;
    prev_data = act;
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) begin
        check(0, "R2", "extra output sample", act, 0);
      end else begin
        check(act == q_data[0], q_tag[0], "data", act, q_data[0]);
        check(out_sof == q_sof[0], "R8", "sof", out_sof, q_sof[0]);
        check(out_eof == q_eof[0], "R8", "eof", out_eof, q_eof[0]);
        void'(q_data.pop_front()); void'(q_sof.pop_front());
        void'(q_eof.pop_front());  void'(q_tag.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      model_accept(pend_pix, pend_sof);
      have = 0;
    end
  endtask

  task automatic drive_pixel(int pix, bit sof);
    pend_pix = pix; pend_sof = sof; have = 1;
    while (have) step();
  endtask

  task automatic send_frame(int mode);
    int p;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        case (mode)
          0: p = r * 40 + c * 3 + 7;
          1: p = (r == ROWS-1 || c == COLS-1) ? 65535 : 0;
          2: p = (r == 0 || c == 0) ? 65535 : 0;
          default: p = int'(lcg[23:8]) ^ (r * 977 + c * 131);
        endcase
        if (mode == 3) void'(rnd_bit());
        drive_pixel(p, r == 0 && c == 0);
      end
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; in_data = '0; in_sof = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", in_ready, 1);

    send_frame(0);                       // steady stream, no stalls
    ready_stall = 1; valid_gap = 1;
    xtag = " R7"; send_frame(1); send_frame(2); xtag = "";
    send_frame(3);
    xtag = " R10";                       // partial frame, then restart
    for (int k = 0; k < 7; k++) drive_pixel(k * 11 + 500, k == 0);
    send_frame(3);
    xtag = "";
    ready_stall = 0; valid_gap = 0;
    send_frame(0);

    while (q_data.size() > 0) step();
    repeat (4) step();
    check(q_data.size() == 0, "R2", "pending samples", q_data.size(), 0);
    finish_run();
  end
endmodule